// File: doc/BRIEF.md
# Dual-FIFO Host Message Interface

This block joins a host register port to a processing engine. It carries two-word messages in both directions. The host uses a single data address for both directions. A write to that address goes into the inbound FIFO. A read from it takes the oldest word out of the outbound FIFO. The engine has its own ports: it pops the inbound FIFO and pushes the outbound FIFO. It can also post a value to a mailbox and log words into a watchpoint FIFO, which the host drains by reading.

The host sees the state of the block in a status word: fill flags for each direction, plus four interrupt flags. A control word holds two groups of bits. The first group decides whether host accesses reach each FIFO. The second group enables each interrupt source. The interrupt output is high while any flag is set and its enable is on. The FIFO depths are parameters. The watchpoint FIFO can be removed by setting its depth to zero.

Top module: `hmi_msg_if`

## Requirements
- R1: After reset all FIFOs are empty. Control and mailbox read 0, `irq` is low, and status (address 1) reads 0x0026_0000: bits 17, 18 and 21 set, all others clear.
- R2: A host write to address 0 pushes `host_wdata` into the inbound FIFO when control bit 25 is set. The engine sees the oldest word on `eng_in_data`, with `eng_in_avail` high. `eng_in_pop` removes that word, and words leave in write order. Status bit 19 means inbound not empty, and bit 17 means inbound not full.
- R3: With an empty inbound FIFO, status bit 17 is still set after the first word of a two-word message has been written.
- R4: `eng_out_push` stores `eng_out_data` in the outbound FIFO. When control bit 24 is set, a host read of address 0 returns the oldest word and removes it. Status bit 16 means outbound not empty, and bit 18 and `eng_out_full` give its fill state.
- R5: A push into a full FIFO is dropped, and a pop from an empty FIFO returns 0 and changes nothing. When control bit 25 is clear, host writes to address 0 are ignored. When control bit 24 is clear, host reads of address 0 return 0 and do not pop.
- R6: A host write to address 2 stores only bits [29:24] and [21:0] of the data. All other bits read back as 0.
- R7: An engine mailbox write stores the value, which the host reads at address 3, and sets status bit 20. A host write of 0x0000_F0F0 to address 3 clears both the value and the flag. A host write of any other value to address 3 is ignored.
- R8: `eng_wp_push` queues a 31-bit word. A host read of address 4 returns the word with bit 31 set and pops it. When the watchpoint FIFO is empty, the read returns 0. Status bit 23 means watchpoint not empty.
- R9: Status bit 21 means inbound empty and bit 22 means outbound not empty. `irq` is the OR of four terms: bit 22 with control bit 16, bit 21 with control bit 17, bit 20 with control bit 18, and bit 23 with control bit 19.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe; pops take effect at the clock edge |
| host_addr | input | 3 | Register select: 0 data, 1 status, 2 control, 3 mailbox, 4 watchpoint |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Combinational read data for `host_addr` |
| eng_in_pop | input | 1 | Engine removes the inbound head word |
| eng_in_data | output | 32 | Inbound head word, 0 when empty |
| eng_in_avail | output | 1 | Inbound FIFO holds a word |
| eng_out_push | input | 1 | Engine pushes an outbound word |
| eng_out_data | input | 32 | Outbound word to push |
| eng_out_full | output | 1 | Outbound FIFO is full |
| eng_mbox_wr | input | 1 | Engine writes the mailbox |
| eng_mbox_data | input | 32 | Mailbox value |
| eng_wp_push | input | 1 | Engine pushes a watchpoint word |
| eng_wp_data | input | 31 | Watchpoint word |
| irq | output | 1 | Interrupt request |

## Verification
Read data on `host_rdata` and `eng_in_data` is combinational from the current state. The bench therefore samples it in the same cycle as the request, shortly after driving it and before the clock edge. Each push, pop or register write takes effect at the next rising edge. Status, control read-back and `irq` reflect that change one cycle after the strobe. The bench drives every access just after a falling edge and releases it just after the rising edge. Every later check therefore sees the state after the update. A bench model holds the FIFO contents, control and mailbox, and predicts each read value, fill flag and interrupt level from that model.

// File: rtl/hmi_pkg.sv
package hmi_pkg;
   localparam int HMI_AW = 3;

   localparam logic [HMI_AW-1:0] A_DATA = 3'd0;
   localparam logic [HMI_AW-1:0] A_STAT = 3'd1;
   localparam logic [HMI_AW-1:0] A_CTRL = 3'd2;
   localparam logic [HMI_AW-1:0] A_MBOX = 3'd3;
   localparam logic [HMI_AW-1:0] A_WPNT = 3'd4;

   // status bit positions
   localparam int S_OUT_NE  = 16;
   localparam int S_IN_NF   = 17;
   localparam int S_OUT_NF  = 18;
   localparam int S_IN_NE   = 19;
   localparam int S_MB_INT  = 20;
   localparam int S_IN_INT  = 21;
   localparam int S_OUT_INT = 22;
   localparam int S_WP_INT  = 23;

   // control bit positions
   localparam int C_OUT_IE = 16;
   localparam int C_IN_IE  = 17;
   localparam int C_MB_IE  = 18;
   localparam int C_WP_IE  = 19;
   localparam int C_OUT_EN = 24;
   localparam int C_IN_EN  = 25;

   localparam logic [31:0] CTRL_KEEP  = 32'h3F3F_FFFF;
   localparam logic [31:0] MBOX_CLEAR = 32'h0000_F0F0;
endpackage

// File: rtl/hmi_fifo.sv
module hmi_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         full
);
   localparam int CW = $clog2(DEPTH + 1);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("hmi_fifo: DEPTH must be at least 1");
      end
      if (W < 1) begin : g_bad_width
         $error("hmi_fifo: W must be at least 1");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] rd_p, wr_p;
   logic [CW-1:0] cnt;
   logic          push_ok, pop_ok;

   assign empty   = (cnt == '0);
   assign full    = (cnt == CW'(DEPTH));
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign head    = empty ? '0 : mem[rd_p];

   function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
      return (p == LAST) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_p] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_p <= '0;
         wr_p <= '0;
         cnt  <= '0;
      end else begin
         if (push_ok) wr_p <= step(wr_p);
         if (pop_ok)  rd_p <= step(rd_p);
         if (push_ok && !pop_ok)      cnt <= cnt + 1'b1;
         else if (pop_ok && !push_ok) cnt <= cnt - 1'b1;
      end
   end
endmodule

// File: rtl/hmi_mailbox.sv
module hmi_mailbox #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         eng_wr,
   input  logic [W-1:0] eng_data,
   input  logic         host_clr,
   output logic [W-1:0] value,
   output logic         flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         value <= '0;
         flag  <= 1'b0;
      end else if (eng_wr) begin
         value <= eng_data;
         flag  <= 1'b1;
      end else if (host_clr) begin
         value <= '0;
         flag  <= 1'b0;
      end
   end
endmodule

// File: rtl/hmi_msg_if.sv
module hmi_msg_if
   import hmi_pkg::*;
#(
   parameter int MSG_DEPTH = 2,
   parameter int WP_DEPTH  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [HMI_AW-1:0] host_addr,
   input  logic [31:0]       host_wdata,
   output logic [31:0]       host_rdata,
   input  logic              eng_in_pop,
   output logic [31:0]       eng_in_data,
   output logic              eng_in_avail,
   input  logic              eng_out_push,
   input  logic [31:0]       eng_out_data,
   output logic              eng_out_full,
   input  logic              eng_mbox_wr,
   input  logic [31:0]       eng_mbox_data,
   input  logic              eng_wp_push,
   input  logic [30:0]       eng_wp_data,
   output logic              irq
);
   generate
      if (MSG_DEPTH < 2) begin : g_bad_msg
         $error("hmi_msg_if: MSG_DEPTH below 2 cannot hold a two-word message");
      end
      if (WP_DEPTH < 0) begin : g_bad_wp
         $error("hmi_msg_if: WP_DEPTH must not be negative");
      end
   endgenerate

   logic [31:0] ctl_q;
   logic        in_empty, in_full, out_empty, out_full, wp_empty;
   logic [31:0] out_head, mbox_val;
   logic [30:0] wp_head;
   logic        mbox_flag;
   logic        in_push, out_pop, wp_pop, mbox_clr;
   logic [31:0] status;
   logic [3:0]  int_src, int_en;

   assign in_push  = host_wr && (host_addr == A_DATA) && ctl_q[C_IN_EN];
   assign out_pop  = host_rd && (host_addr == A_DATA) && ctl_q[C_OUT_EN];
   assign wp_pop   = host_rd && (host_addr == A_WPNT);
   assign mbox_clr = host_wr && (host_addr == A_MBOX) && (host_wdata == MBOX_CLEAR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                ctl_q <= '0;
      else if (host_wr && host_addr == A_CTRL)   ctl_q <= host_wdata & CTRL_KEEP;
   end

   hmi_fifo #(.W(32), .DEPTH(MSG_DEPTH)) u_in_fifo (
      .clk(clk), .rst_n(rst_n), .push(in_push), .din(host_wdata),
      .pop(eng_in_pop), .head(eng_in_data), .empty(in_empty), .full(in_full));

   hmi_fifo #(.W(32), .DEPTH(MSG_DEPTH)) u_out_fifo (
      .clk(clk), .rst_n(rst_n), .push(eng_out_push), .din(eng_out_data),
      .pop(out_pop), .head(out_head), .empty(out_empty), .full(out_full));

   generate
      if (WP_DEPTH > 0) begin : g_wp
         hmi_fifo #(.W(31), .DEPTH(WP_DEPTH)) u_wp_fifo (
            .clk(clk), .rst_n(rst_n), .push(eng_wp_push), .din(eng_wp_data),
            .pop(wp_pop), .head(wp_head), .empty(wp_empty), .full());
      end else begin : g_no_wp
         logic unused_wp;
         assign unused_wp = eng_wp_push ^ (|eng_wp_data) ^ wp_pop;
         assign wp_head   = '0;
         assign wp_empty  = 1'b1;
      end
   endgenerate

   hmi_mailbox #(.W(32)) u_mbox (
      .clk(clk), .rst_n(rst_n), .eng_wr(eng_mbox_wr), .eng_data(eng_mbox_data),
      .host_clr(mbox_clr), .value(mbox_val), .flag(mbox_flag));

   assign eng_in_avail = !in_empty;
   assign eng_out_full = out_full;

   always_comb begin
      status            = '0;
      status[S_OUT_NE]  = !out_empty;
      status[S_IN_NF]   = !in_full;
      status[S_OUT_NF]  = !out_full;
      status[S_IN_NE]   = !in_empty;
      status[S_MB_INT]  = mbox_flag;
      status[S_IN_INT]  = in_empty;
      status[S_OUT_INT] = !out_empty;
      status[S_WP_INT]  = !wp_empty;
   end

   assign int_src = {status[S_WP_INT], status[S_MB_INT], status[S_IN_INT], status[S_OUT_INT]};
   assign int_en  = {ctl_q[C_WP_IE], ctl_q[C_MB_IE], ctl_q[C_IN_IE], ctl_q[C_OUT_IE]};
   assign irq     = |(int_src & int_en);

   always_comb begin
      unique case (host_addr)
         A_DATA:  host_rdata = ctl_q[C_OUT_EN] ? out_head : '0;
         A_STAT:  host_rdata = status;
         A_CTRL:  host_rdata = ctl_q;
         A_MBOX:  host_rdata = mbox_val;
         A_WPNT:  host_rdata = {!wp_empty, wp_head};
         default: host_rdata = '0;
      endcase
   end
endmodule

// File: rtl/hmi_msg_if_chk.sv
module hmi_msg_if_chk
   import hmi_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              host_wr,
   input logic              host_rd,
   input logic [HMI_AW-1:0] host_addr,
   input logic [31:0]       host_wdata,
   input logic [31:0]       host_rdata,
   input logic              eng_in_pop,
   input logic [31:0]       eng_in_data,
   input logic              eng_mbox_wr,
   input logic              in_empty,
   input logic              in_full,
   input logic              out_empty,
   input logic              mbox_flag,
   input logic [31:0]       ctl_q,
   input logic              irq
);
   AST_FIRST_WORD_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr && host_addr == A_DATA && ctl_q[C_IN_EN] && in_empty |=> !in_full); // R3

   AST_EMPTY_POP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      host_rd && host_addr == A_DATA && out_empty |-> host_rdata == 32'd0); // R5

   AST_FULL_PUSH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr && host_addr == A_DATA && in_full && !eng_in_pop |=> in_full && $stable(eng_in_data)); // R5

   AST_CTRL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr && host_addr == A_CTRL |=> ctl_q == ($past(host_wdata) & CTRL_KEEP)); // R6

   AST_MBOX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr && host_addr == A_MBOX && host_wdata == MBOX_CLEAR && !eng_mbox_wr |=> !mbox_flag); // R7

   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_q[19:16] == 4'd0 |-> !irq); // R9
endmodule

bind hmi_msg_if hmi_msg_if_chk u_chk (.*);

// File: tb/test_hmi_msg_if.sv
`timescale 1ns/1ps
module test_hmi_msg_if;
   localparam int D = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 0, host_rd = 0;
   logic [2:0]  host_addr = '0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        eng_in_pop = 0;
   logic [31:0] eng_in_data;
   logic        eng_in_avail;
   logic        eng_out_push = 0;
   logic [31:0] eng_out_data = '0;
   logic        eng_out_full;
   logic        eng_mbox_wr = 0;
   logic [31:0] eng_mbox_data = '0;
   logic        eng_wp_push = 0;
   logic [30:0] eng_wp_data = '0;
   logic        irq;

   hmi_msg_if i_hmi_msg_if (.*);

   always #10 clk = ~clk;

   int checks = 0, fails = 0;
   bit done = 0;

   // bench model
   logic [31:0] in_q [D];  int in_n = 0;
   logic [31:0] out_q [D]; int out_n = 0;
   logic [30:0] wp_q [D];  int wp_n = 0;
   logic [31:0] m_ctl = 0, m_mbox = 0;
   bit          m_mflag = 0;

   function automatic logic [31:0] exp_stat();
      logic [31:0] s = '0;
      s[16] = out_n > 0;  s[17] = in_n < D;  s[18] = out_n < D;  s[19] = in_n > 0;
      s[20] = m_mflag;    s[21] = in_n == 0; s[22] = out_n > 0;  s[23] = wp_n > 0;
      return s;
   endfunction

   function automatic logic exp_irq();
      logic [31:0] s = exp_stat();
      return (s[22] & m_ctl[16]) | (s[21] & m_ctl[17]) | (s[20] & m_ctl[18]) | (s[23] & m_ctl[19]);
   endfunction

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   task automatic release_all();
      host_wr = 0; host_rd = 0; eng_in_pop = 0; eng_out_push = 0;
      eng_mbox_wr = 0; eng_wp_push = 0;
   endtask

   task automatic host_write(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1;
      @(posedge clk); #1 release_all();
   endtask

   task automatic host_read(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk); host_addr = a; host_rd = 1; #1 d = host_rdata;
      @(posedge clk); #1 release_all();
   endtask

   task automatic hw_fifo(input logic [31:0] d);
      if (m_ctl[25] && in_n < D) begin in_q[in_n] = d; in_n++; end
      host_write(3'd0, d);
   endtask

   task automatic hr_fifo(input string tag);
      logic [31:0] r, e;
      e = (m_ctl[24] && out_n > 0) ? out_q[0] : 32'd0;
      host_read(3'd0, r);
      chk(r, e, tag);
      if (m_ctl[24] && out_n > 0) begin
         for (int i = 0; i < D - 1; i++) out_q[i] = out_q[i+1];
         out_n--;
      end
   endtask

   task automatic eng_push(input logic [31:0] d);
      if (out_n < D) begin out_q[out_n] = d; out_n++; end
      @(negedge clk); eng_out_data = d; eng_out_push = 1;
      @(posedge clk); #1 release_all();
   endtask

   task automatic eng_pop(input string tag);
      @(negedge clk);
      chk({31'd0, eng_in_avail}, {31'd0, in_n > 0}, tag);
      chk(eng_in_data, (in_n > 0) ? in_q[0] : 32'd0, tag);
      eng_in_pop = 1;
      @(posedge clk); #1 release_all();
      if (in_n > 0) begin
         for (int i = 0; i < D - 1; i++) in_q[i] = in_q[i+1];
         in_n--;
      end
   endtask

   task automatic wp_push(input logic [30:0] d);
      if (wp_n < D) begin wp_q[wp_n] = d; wp_n++; end
      @(negedge clk); eng_wp_data = d; eng_wp_push = 1;
      @(posedge clk); #1 release_all();
   endtask

   task automatic wp_read(input string tag);
      logic [31:0] r;
      host_read(3'd4, r);
      chk(r, (wp_n > 0) ? {1'b1, wp_q[0]} : 32'd0, tag);
      if (wp_n > 0) begin
         for (int i = 0; i < D - 1; i++) wp_q[i] = wp_q[i+1];
         wp_n--;
      end
   endtask

   task automatic set_ctl(input logic [31:0] d);
      m_ctl = d & 32'h3F3F_FFFF;
      host_write(3'd2, d);
   endtask

   task automatic chk_stat(input string tag);
      logic [31:0] r;
      host_read(3'd1, r);
      chk(r, exp_stat(), tag);
      chk({31'd0, irq}, {31'd0, exp_irq()}, tag);
   endtask

   initial begin : watchdog
      #(20 * 150000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] r;
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      #1 rst_n = 1;

      // R1 reset state
      chk({31'd0, irq}, 32'd0, "R1 irq");
      chk_stat("R1 status");
      host_read(3'd1, r); chk(r, 32'h0026_0000, "R1 status value");
      host_read(3'd2, r); chk(r, 32'd0, "R1 control");
      host_read(3'd3, r); chk(r, 32'd0, "R1 mailbox");

      // R5 FIFO access with enables clear
      hw_fifo(32'h1111_0001);
      chk_stat("R5 disabled write ignored");
      eng_push(32'h2222_0001);
      hr_fifo("R5 disabled read zero");
      chk_stat("R5 disabled read no pop");

      // R6 control mask
      set_ctl(32'hFFFF_FFFF);
      host_read(3'd2, r); chk(r, 32'h3F3F_FFFF, "R6 control mask");
      chk({31'd0, irq}, {31'd0, exp_irq()}, "R9 irq all enabled");
      set_ctl(32'h0300_0000);
      chk({31'd0, irq}, 32'd0, "R9 irq masked");
      hr_fifo("R4 drain outbound");

      // R2 / R3 / R5 inbound
      hw_fifo(32'hA000_0001);
      chk_stat("R3 room after first word");
      host_read(3'd1, r); chk({31'd0, r[17]}, 32'd1, "R3 not full bit");
      hw_fifo(32'hA000_0002);
      chk_stat("R2 inbound full");
      hw_fifo(32'hA000_0003);
      chk_stat("R5 push on full dropped");
      eng_pop("R2 first word");
      eng_pop("R2 second word");
      eng_pop("R5 pop on empty");
      chk_stat("R2 inbound empty again");

      // R4 / R5 outbound
      eng_push(32'hB000_0001);
      eng_push(32'hB000_0002);
      chk({31'd0, eng_out_full}, 32'd1, "R4 outbound full");
      eng_push(32'hB000_0003);
      chk_stat("R4 outbound status");
      hr_fifo("R4 word one");
      hr_fifo("R4 word two");
      hr_fifo("R5 read on empty");
      chk({31'd0, eng_out_full}, 32'd0, "R4 outbound not full");

      // R7 mailbox
      @(negedge clk); eng_mbox_data = 32'h1234_5678; eng_mbox_wr = 1;
      @(posedge clk); #1 release_all();
      m_mbox = 32'h1234_5678; m_mflag = 1;
      host_read(3'd3, r); chk(r, m_mbox, "R7 mailbox value");
      chk_stat("R7 mailbox flag");
      set_ctl(32'h0304_0000);
      chk({31'd0, irq}, 32'd1, "R9 mailbox irq");
      host_write(3'd3, 32'h0000_F0F1);
      host_read(3'd3, r); chk(r, m_mbox, "R7 other value ignored");
      host_write(3'd3, 32'h0000_F0F0);
      m_mbox = 0; m_mflag = 0;
      host_read(3'd3, r); chk(r, 32'd0, "R7 mailbox cleared");
      chk_stat("R7 flag cleared");

      // R8 watchpoint
      wp_push(31'h1ABC_DEF0);
      wp_push(31'h0000_0005);
      set_ctl(32'h0308_0000);
      chk_stat("R8 watchpoint status");
      wp_read("R8 first entry");
      wp_read("R8 second entry");
      wp_read("R8 empty read");
      chk_stat("R8 watchpoint drained");

      // random traffic
      set_ctl(32'h030F_0000);
      for (int it = 0; it < 600; it++) begin
         int op = $urandom_range(0, 5);
         case (op)
            0: hw_fifo($urandom());
            1: eng_pop("R2 random engine pop");
            2: eng_push($urandom());
            3: hr_fifo("R4 random host pop");
            4: chk_stat("R9 random status");
            default: if ($urandom_range(0, 3) == 0)
                        set_ctl({6'd0, 2'($urandom_range(0, 3)), 8'd0, 12'd0, 4'($urandom())} << 0 | 32'h0000_0000 |
                                ({6'd0, 2'b11, 24'd0}) | ({12'd0, 4'($urandom()), 16'd0}));
                     else chk_stat("R9 random irq");
         endcase
      end
      set_ctl(32'h0300_0000);
      chk_stat("R9 final status");

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule